// File: doc/BRIEF.md
# Memory-Controller Performance Counter Unit

This block counts activity next to a memory controller. Counter 0 counts clock cycles only. Counters 1 to 3 each count the cycles in which one chosen line of an event bus is high. Software sets up and reads the counters through a simple word-addressed register port. Writes take effect at the next clock edge. Reads are combinational.

Counter 0 acts as the time base for the whole unit. When it is disabled, every counter stops in the same cycle. When it wraps past its all-ones value, it locks every counter and raises a level interrupt. Writing counter 0's clear bit zeroes it, releases the lock and drops the interrupt.

The parameter `STOP_ON_OVF` sets how the event counters overflow. With the parameter at 0 they wrap freely. With it at 1 they hold at all-ones until cleared. An event overflow never raises the interrupt in either mode. A per-counter sticky overflow flag lets software tell a stopped counter from an idle one.

Top module: `mc_perf_unit`

## Requirements
- R1: After reset, all counter values, control registers and overflow flags read 0, and `irq` is 0.
- R2: Counter 0 (control at 0x00, enable in bit 0) increments by one on every clock edge while it is enabled and the lock is clear.
- R3: Event counter i (i = 1..3, control at 4*i) increments on an edge when four conditions all hold: its enable bit 0 is set, `evt_in[sel]` is 1 (sel being control bits [6:4]), counter 0 is enabled and the lock is clear.
- R4: Writing counter 0's enable to 0 stops every counter from the next edge on. Setting it back to 1 lets all counters resume together.
- R5: When counter 0 increments from all-ones, it becomes 0, the lock sets, and `irq` reads 1 from the next cycle. While the lock is set, no counter changes except through a clear.
- R6: `irq` is a level that stays 1 until a write to 0x00 with bit 1 (clear) set. That write zeroes counter 0, clears the lock and drops `irq` on the next cycle.
- R7: With STOP_ON_OVF=0, an event counter that increments from all-ones wraps to 0, keeps counting and sets its overflow flag.
- R8: With STOP_ON_OVF=1, an event counter that receives an event at all-ones keeps the all-ones value, sets its overflow flag, and ignores further events until it is cleared.
- R9: An event counter overflow never asserts `irq`.
- R10: A control write with bit 1 set zeroes that counter and its overflow flag on the next cycle. The write also loads the enable and sel fields from the written data. An event in the same cycle is dropped. The clear bit always reads back 0.
- R11: The status word at 0x20 holds the sticky overflow flag of counter k in bit k (k = 0..3).
- R12: Counter k's value reads at 0x10 + 4*k, zero-extended. Control reads return enable in bit 0 and sel in bits [6:4]. Unmapped word addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (6) | Byte address of the register word |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| evt_in | input | EVT_N (8) | Event pulse lines from the memory controller |
| irq | output | 1 | Level interrupt: cycle counter has overflowed and locked the unit |

## Verification
The bench runs two copies of the unit side by side, one in each overflow mode, both built with 8-bit counters so that wraps can be reached. Three kinds of stimulus are used:
- A steady all-ones event bus drives both event counter kinds through overflow. This separates wrap-and-continue from hold-at-all-ones, and shows that the interrupt stays low.
- Letting counter 0 run out shows the global freeze and the interrupt. Toggling counter 0's enable shows that all counters stop and start together.
- Random event bus values mixed with random control writes test event selection, clear-over-event priority and clear-only restarts against the bench's own model.

// File: rtl/mc_perf_pkg.sv
package mc_perf_pkg;
    // control register field positions
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_CLR_BIT = 1;
    localparam int CTL_SEL_LSB = 4;
endpackage

// File: rtl/mc_perf_cyc_cnt.sv
module mc_perf_cyc_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             wr_en,
    input  logic             wr_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             en,
    output logic             run,
    output logic             lock
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             en;
        logic             lock;
    } cyc_st_t;

    cyc_st_t s_d, s_q;
    logic    clr_hit;

    always_comb begin
        s_d     = s_q;
        clr_hit = ctl_we && wr_clr;
        if (ctl_we) begin
            s_d.en = wr_en;
        end
        if (clr_hit) begin
            s_d.cnt  = '0;
            s_d.ovf  = 1'b0;
            s_d.lock = 1'b0;
        end else if (s_q.en && !s_q.lock) begin
            if (s_q.cnt == CNT_MAX) begin
                s_d.cnt  = '0;
                s_d.ovf  = 1'b1;
                s_d.lock = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt  = s_q.cnt;
    assign ovf  = s_q.ovf;
    assign en   = s_q.en;
    assign lock = s_q.lock;
    assign run  = s_q.en && !s_q.lock;

    // R5
    lock_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lock && !(ctl_we && wr_clr)) |=> ($stable(s_q.cnt) && s_q.lock));

    // R6
    lock_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && wr_clr) |=> (!s_q.lock && s_q.cnt == '0));

    // R2
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && !s_q.lock && !(ctl_we && wr_clr) && s_q.cnt != CNT_MAX)
        |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));
endmodule

// File: rtl/mc_perf_evt_cnt.sv
module mc_perf_evt_cnt #(
    parameter int CNT_W       = 32,
    parameter int EVT_N       = 8,
    parameter int SEL_W       = 3,
    parameter bit STOP_ON_OVF = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             wr_en,
    input  logic             wr_clr,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [EVT_N-1:0] evt_in,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             en,
    output logic [SEL_W-1:0] sel
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             en;
        logic [SEL_W-1:0] sel;
    } evt_st_t;

    evt_st_t          s_d, s_q;
    logic             evt_hit;
    logic             halted;
    logic [CNT_W-1:0] wrap_val;

    generate
        if (STOP_ON_OVF) begin : g_hold
            assign halted   = s_q.ovf;
            assign wrap_val = CNT_MAX;
        end else begin : g_wrap
            assign halted   = 1'b0;
            assign wrap_val = '0;
        end
    endgenerate

    always_comb begin
        s_d     = s_q;
        evt_hit = run && s_q.en && evt_in[s_q.sel] && !halted;
        if (ctl_we) begin
            s_d.en  = wr_en;
            s_d.sel = wr_sel;
        end
        if (ctl_we && wr_clr) begin
            s_d.cnt = '0;
            s_d.ovf = 1'b0;
        end else if (evt_hit) begin
            if (s_q.cnt == CNT_MAX) begin
                s_d.cnt = wrap_val;
                s_d.ovf = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;
    assign ovf = s_q.ovf;
    assign en  = s_q.en;
    assign sel = s_q.sel;

    // R10
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && wr_clr) |=> (s_q.cnt == '0 && !s_q.ovf));

    // R4
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(ctl_we && wr_clr)) |=> $stable(s_q.cnt));

    generate
        if (STOP_ON_OVF) begin : g_hold_chk
            // R8
            stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (s_q.ovf && !(ctl_we && wr_clr)) |=> $stable(s_q.cnt));
        end else begin : g_wrap_chk
            // R7
            wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (run && s_q.en && evt_in[s_q.sel] && s_q.cnt == CNT_MAX
                 && !(ctl_we && wr_clr)) |=> (s_q.cnt == '0 && s_q.ovf));
        end
    endgenerate
endmodule

// File: rtl/mc_perf_unit.sv
module mc_perf_unit #(
    parameter int CNT_W       = 32,
    parameter int NUM_EVT     = 3,
    parameter int EVT_N       = 8,
    parameter int DATA_W      = 32,
    parameter int REG_AW      = 6,
    parameter bit STOP_ON_OVF = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EVT_N-1:0]  evt_in,
    output logic              irq
);
    import mc_perf_pkg::*;

    localparam int NUM_CNT = NUM_EVT + 1;
    localparam int SEL_W   = (EVT_N > 1) ? $clog2(EVT_N) : 1;
    localparam int IDX_W   = REG_AW - 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [IDX_W-1:0]   widx;
    logic [NUM_CNT-1:0] ctl_we;
    logic [CNT_W-1:0]   cnt_v [NUM_CNT];
    logic [SEL_W-1:0]   sel_v [NUM_CNT];
    logic [NUM_CNT-1:0] en_v;
    logic [NUM_CNT-1:0] ovf_v;
    logic               cyc_run;
    logic               cyc_lock;
    logic               wr_en_f;
    logic               wr_clr_f;
    logic [SEL_W-1:0]   wr_sel_f;
    logic               unused_wbits;

    assign widx         = reg_addr[REG_AW-1:2];
    assign wr_en_f      = reg_wdata[CTL_EN_BIT];
    assign wr_clr_f     = reg_wdata[CTL_CLR_BIT];
    assign wr_sel_f     = reg_wdata[CTL_SEL_LSB +: SEL_W];
    assign unused_wbits = ^{reg_wdata, reg_addr[1:0]};

    always_comb begin
        for (int i = 0; i < NUM_CNT; i++) begin
            ctl_we[i] = reg_we && (widx == IDX_W'(i));
        end
    end

    mc_perf_cyc_cnt #(.CNT_W(CNT_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_we (ctl_we[0]),
        .wr_en  (wr_en_f),
        .wr_clr (wr_clr_f),
        .cnt    (cnt_v[0]),
        .ovf    (ovf_v[0]),
        .en     (en_v[0]),
        .run    (cyc_run),
        .lock   (cyc_lock)
    );
    assign sel_v[0] = '0;

    for (genvar g = 1; g < NUM_CNT; g++) begin : g_evt
        mc_perf_evt_cnt #(
            .CNT_W       (CNT_W),
            .EVT_N       (EVT_N),
            .SEL_W       (SEL_W),
            .STOP_ON_OVF (STOP_ON_OVF)
        ) u_evt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl_we (ctl_we[g]),
            .wr_en  (wr_en_f),
            .wr_clr (wr_clr_f),
            .wr_sel (wr_sel_f),
            .evt_in (evt_in),
            .run    (cyc_run),
            .cnt    (cnt_v[g]),
            .ovf    (ovf_v[g]),
            .en     (en_v[g]),
            .sel    (sel_v[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (widx == IDX_W'(i)) begin
                reg_rdata[CTL_EN_BIT]             = en_v[i];
                reg_rdata[CTL_SEL_LSB +: SEL_W]   = sel_v[i];
            end
            if (widx == IDX_W'(NUM_CNT + i)) begin
                reg_rdata[CNT_W-1:0] = cnt_v[i];
            end
        end
        if (widx == IDX_W'(2 * NUM_CNT)) begin
            reg_rdata[NUM_CNT-1:0] = ovf_v;
        end
    end

    assign irq = cyc_lock;

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cnt_v[0]) == CNT_MAX));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(cyc_run && cnt_v[0] == CNT_MAX)) |=> !irq);

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(ctl_we[0] && wr_clr_f)) |=> irq);
endmodule

// File: tb/mc_perf_unit_bench.sv
`timescale 1ns/100ps
module mc_perf_unit_bench;
    localparam int W = 8;
    localparam logic [W-1:0] MAXV = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0]  evt = '0;
    logic [31:0] rdata_s, rdata_f;
    logic        irq_s, irq_f;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model state: index 0 = stop-on-overflow unit, 1 = free-running unit
    logic [W-1:0] m_cnt [2][4];
    logic         m_ovf [2][4];
    logic         m_en  [2][4];
    logic [2:0]   m_sel [2][4];
    logic         m_lock[2];

    always #2.5 clk = ~clk;

    mc_perf_unit #(.CNT_W(W), .STOP_ON_OVF(1'b1)) u_mc_perf_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata_s), .evt_in(evt), .irq(irq_s)
    );

    mc_perf_unit #(.CNT_W(W), .STOP_ON_OVF(1'b0)) u_mc_perf_unit_free (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata_f), .evt_in(evt), .irq(irq_f)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            m_lock[m] = 1'b0;
            for (int i = 0; i < 4; i++) begin
                m_cnt[m][i] = '0; m_ovf[m][i] = 1'b0;
                m_en[m][i] = 1'b0; m_sel[m][i] = '0;
            end
        end
    endtask

    task automatic model_step();
        for (int m = 0; m < 2; m++) begin
            logic run;
            run = m_en[m][0] && !m_lock[m];
            for (int i = 1; i < 4; i++) begin
                logic hit, wr, clr;
                wr  = we && (addr[5:2] == 4'(i));
                clr = wr && wdata[1];
                hit = run && m_en[m][i] && evt[m_sel[m][i]] && !(m == 0 && m_ovf[m][i]);
                if (clr) begin
                    m_cnt[m][i] = '0; m_ovf[m][i] = 1'b0;
                end else if (hit) begin
                    if (m_cnt[m][i] == MAXV) begin
                        m_ovf[m][i] = 1'b1;
                        if (m == 1) m_cnt[m][i] = '0;
                    end else begin
                        m_cnt[m][i] = m_cnt[m][i] + 1'b1;
                    end
                end
                if (wr) begin
                    m_en[m][i] = wdata[0]; m_sel[m][i] = wdata[6:4];
                end
            end
            if (we && addr[5:2] == 4'd0 && wdata[1]) begin
                m_cnt[m][0] = '0; m_ovf[m][0] = 1'b0; m_lock[m] = 1'b0;
            end else if (run) begin
                if (m_cnt[m][0] == MAXV) begin
                    m_cnt[m][0] = '0; m_ovf[m][0] = 1'b1; m_lock[m] = 1'b1;
                end else begin
                    m_cnt[m][0] = m_cnt[m][0] + 1'b1;
                end
            end
            if (we && addr[5:2] == 4'd0) m_en[m][0] = wdata[0];
        end
    endtask

    function automatic logic [31:0] exp_reg(input int m, input int idx);
        logic [31:0] v;
        v = '0;
        if (idx < 4) begin
            v[0] = m_en[m][idx]; v[6:4] = m_sel[m][idx];
        end else if (idx < 8) begin
            v[W-1:0] = m_cnt[m][idx-4];
        end else if (idx == 8) begin
            for (int k = 0; k < 4; k++) v[k] = m_ovf[m][k];
        end
        return v;
    endfunction

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_ctl(input int i, input bit en, input bit clr, input logic [2:0] sel);
        we = 1'b1; addr = 6'(i * 4);
        wdata = {25'd0, sel, 2'b00, clr, en};
        tick();
        we = 1'b0; wdata = '0;
    endtask

    task automatic chk_all(input string tag);
        string t;
        for (int idx = 0; idx < 10; idx++) begin
            addr = 6'(idx * 4);
            #0.2;
            if (idx < 4) t = {tag, " R12 ctl"};
            else if (idx == 4) t = {tag, " R2 cycle count"};
            else if (idx < 8) t = {tag, " R3 event count"};
            else if (idx == 8) t = {tag, " R11 status"};
            else t = {tag, " R12 unmapped"};
            chk({t, " stop"}, rdata_s, exp_reg(0, idx));
            chk({t, " free"}, rdata_f, exp_reg(1, idx));
        end
        chk({tag, " irq stop"}, 32'(irq_s), 32'(m_lock[0]));
        chk({tag, " irq free"}, 32'(irq_f), 32'(m_lock[1]));
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2874));
        model_reset();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        #0.5;
        chk_all("R1");

        // selection and basic counting
        write_ctl(1, 1'b1, 1'b0, 3'd0);
        write_ctl(2, 1'b1, 1'b0, 3'd1);
        write_ctl(3, 1'b1, 1'b0, 3'd2);
        write_ctl(0, 1'b1, 1'b0, 3'd0);
        for (int c = 0; c < 20; c++) begin
            evt = 8'($urandom); tick();
        end
        chk_all("R3");

        // global stop by counter 0 enable
        write_ctl(0, 1'b0, 1'b0, 3'd0);
        evt = 8'hFF;
        for (int c = 0; c < 10; c++) tick();
        chk_all("R4 stopped");
        write_ctl(0, 1'b1, 1'b0, 3'd0);
        for (int c = 0; c < 5; c++) tick();
        chk_all("R4 resumed");

        // clear coinciding with an event
        write_ctl(1, 1'b1, 1'b1, 3'd0);
        addr = 6'h14; #0.2;
        chk("R10 clear drops event stop", rdata_s, 32'd0);
        chk("R10 clear drops event free", rdata_f, 32'd0);
        addr = 6'h04; #0.2;
        chk("R10 clear bit reads 0", rdata_s, 32'd1);

        // event overflow in both modes, counter 0 kept short of overflow
        for (int c = 0; c < 300; c++) begin
            if (c % 100 == 0) write_ctl(0, 1'b1, 1'b1, 3'd0);
            else tick();
        end
        chk_all("R7 R8");
        chk("R9 no irq on event overflow stop", 32'(irq_s), 32'd0);
        chk("R9 no irq on event overflow free", 32'(irq_f), 32'd0);
        addr = 6'h20; #0.2;
        chk("R11 status stop", rdata_s, 32'he);
        addr = 6'h18; #0.2;
        chk("R8 held at all-ones", rdata_s, 32'(MAXV));

        // cycle counter overflow and global lock
        write_ctl(0, 1'b1, 1'b1, 3'd0);
        for (int c = 0; c < 270; c++) tick();
        chk("R5 irq raised", 32'(irq_s), 32'd1);
        chk_all("R5 locked");
        for (int c = 0; c < 10; c++) begin
            evt = 8'($urandom); tick();
        end
        chk_all("R5 frozen");
        write_ctl(0, 1'b1, 1'b1, 3'd0);
        chk("R6 irq released", 32'(irq_f), 32'd0);
        chk_all("R6");

        // random traffic
        for (int c = 0; c < 2000; c++) begin
            evt = 8'($urandom);
            if ($urandom % 16 == 0) begin
                int i;
                i = int'($urandom % 4);
                write_ctl(i, ($urandom % 4) != 0, ($urandom % 4) == 0, 3'($urandom));
            end else begin
                tick();
            end
            if (c % 8 == 7) chk_all("R10 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule